// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block contains two timer/counters. Each one holds its count in a low byte and a high byte. Each timer has a run bit and an optional gate that ties counting to an external level pin. It also has a source select: it counts either machine-cycle ticks, which come from the core clock divided by `DIV`, or falling edges seen on an external count pin. A 2-bit mode field per timer chooses one of four structures:

- a 13-bit count with a 5-bit prescaler;
- a plain 16-bit count;
- an 8-bit count that reloads from the high byte;
- a split arrangement in which timer 0 becomes two independent 8-bit counters.

A small host port gives read and write access to the four count bytes, the configuration byte and the control byte. Each timer drives a sticky overflow flag. The flag is cleared by writing 1 to its control bit or by pulsing the matching acknowledge input.

Register map (`addr`): 0 = timer 0 low byte, 1 = timer 0 high byte, 2 = timer 1 low byte, 3 = timer 1 high byte, 4 = configuration, 5 = control. Addresses 6 and 7 read as zero.

Configuration byte: bits [3:0] belong to timer 0 and bits [7:4] to timer 1. Within each nibble:
- bits [1:0] hold the mode (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split);
- bit 2 selects the external count pin;
- bit 3 enables the gate.

Control byte: bit 0 = run 0, bit 1 = run 1, bit 2 = flag 0, bit 3 = flag 1.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all count bytes, the configuration byte, the run bits and both flags are zero. `rd_data` returns 0 for addresses 0 to 5, and `ovf` is 0.
- R2: A timer advances only when its run bit is 1 and either its gate bit (configuration bit 3 or 7) is 0 or its `gate_pin` is 1. Otherwise its count is unchanged.
- R3: With the external-pin bit at 0, a running timer advances exactly once per `DIV` clock cycles.
- R4: With the external-pin bit at 1, `cnt_pin` is sampled once per machine cycle. A sample of 1 followed by a sample of 0 on the next machine cycle gives exactly one increment.
- R5: Mode 0 counts the 13-bit value {high byte, low byte bits [4:0]}. Low-byte bits [7:5] are never changed by counting. A wrap from 1FFF to 0 sets the timer's flag.
- R6: Mode 1 counts {high, low} as 16 bits. A wrap from FFFF to 0000 sets the timer's flag.
- R7: Mode 2 counts the low byte only. When the low byte is FF, the next increment loads the high byte into it and sets the flag. The high byte is never changed by counting.
- R8: With timer 0 in mode 3, timer 0's low byte counts under timer 0's own run, gate and source settings and sets flag 0 on FF to 00. Timer 0's high byte counts machine cycles whenever run 1 is set and sets flag 1 on FF to 00. While this holds, timer 1 still counts under run 1, but its own overflow does not set flag 1.
- R9: Timer 1 in mode 3 holds its count and never sets a flag.
- R10: A flag is cleared by its `ack` bit or by a host write of 1 to control bit 2 (flag 0) or bit 3 (flag 1). Writing 0 to those bits leaves the flag as it is. When an overflow falls in the same cycle as a clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Host register address, shared by reads and writes |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data for `addr` (combinational) |
| cnt_pin | input | 2 | External count pins; bit i belongs to timer i |
| gate_pin | input | 2 | External gate level pins; bit i belongs to timer i |
| ack | input | 2 | Flag acknowledge; bit i clears flag i |
| ovf | output | 2 | Sticky overflow flags |

## Verification
An overflow that sets a flag can land in the same clock cycle as an acknowledge pulse that clears it. Only the rule that a set beats a clear keeps the event from being lost.

The bench first finds the machine-cycle phase at the ports. It runs timer 0 in reload mode from FE and polls the low byte until it reads FF, which marks a tick edge. It then raises `ack[0]` exactly `DIV` clocks later, so the acknowledge coincides with the reload overflow. Just before that edge, `ovf[0]` must still be 0. Just after it, `ovf[0]` must read 1. A later acknowledge pulse with the timer stopped must bring the flag back to 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  // one configuration nibble per timer
  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned CFG_BITS = 4;
  localparam int unsigned PRE_BITS = 5;

  localparam logic [2:0] ADDR_T0_LO = 3'd0;
  localparam logic [2:0] ADDR_T0_HI = 3'd1;
  localparam logic [2:0] ADDR_T1_LO = 3'd2;
  localparam logic [2:0] ADDR_T1_HI = 3'd3;
  localparam logic [2:0] ADDR_CFG   = 3'd4;
  localparam logic [2:0] ADDR_CTRL  = 3'd5;

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic smp_q;

  assign fall = tick & smp_q & ~pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    smp_q <= 1'b0;
    else if (tick) smp_q <= pin;
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter bit SPLIT = 1'b1,
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         inc_lo,
  input  logic         inc_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf_main,
  output logic         ovf_hi
);
  localparam logic [W-1:0]        ONES  = '1;
  localparam logic [PRE_BITS-1:0] PONES = '1;

  logic [W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [W-1:0] sp_lo, sp_hi;
  logic         sp_ovf_lo, sp_ovf_hi;

  // variant chosen for mode 3
  if (SPLIT) begin : g_split
    always_comb begin
      sp_lo     = inc_lo ? lo_q + 1'b1 : lo_q;
      sp_hi     = inc_hi ? hi_q + 1'b1 : hi_q;
      sp_ovf_lo = inc_lo & (lo_q == ONES);
      sp_ovf_hi = inc_hi & (hi_q == ONES);
    end
  end else begin : g_hold
    logic unused_inc;
    assign unused_inc = inc_hi;
    always_comb begin
      sp_lo     = lo_q;
      sp_hi     = hi_q;
      sp_ovf_lo = 1'b0;
      sp_ovf_hi = 1'b0;
    end
  end

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    unique case (mode)
      MODE_13: if (inc_lo) begin
        lo_d[PRE_BITS-1:0] = lo_q[PRE_BITS-1:0] + 1'b1;
        if (lo_q[PRE_BITS-1:0] == PONES) begin
          hi_d     = hi_q + 1'b1;
          ovf_main = (hi_q == ONES);
        end
      end
      MODE_16: if (inc_lo) begin
        {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
        ovf_main     = (hi_q == ONES) && (lo_q == ONES);
      end
      MODE_RELOAD: if (inc_lo) begin
        if (lo_q == ONES) begin
          lo_d     = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      MODE_SPLIT: begin
        lo_d     = sp_lo;
        hi_d     = sp_hi;
        ovf_main = sp_ovf_lo;
        ovf_hi   = sp_ovf_hi;
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] ack,
  output logic [1:0] ovf
);
  localparam int unsigned CFGW = NUM_TMR * CFG_BITS;

  logic            tick;
  logic [CFGW-1:0] cfg_q, cfg_d;
  logic [1:0]      run_q, run_d, flag_q, flag_d;
  logic [1:0]      fall, en, inc, set_flag;
  logic [1:0]      ovf_main, ovf_hi;
  logic [7:0]      cnt_lo [NUM_TMR];
  logic [7:0]      cnt_hi [NUM_TMR];
  tmr_cfg_t        cfg [NUM_TMR];
  logic            wr_cfg, wr_ctrl, t0_split;

  tmr_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign wr_cfg   = wr_en && (addr == ADDR_CFG);
  assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);
  assign t0_split = (cfg[0].mode == MODE_SPLIT);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [2:0] A_LO = 3'(2 * i);
    localparam logic [2:0] A_HI = 3'(2 * i + 1);
    logic inc_hi_i;

    assign cfg[i] = tmr_cfg_t'(cfg_q[CFG_BITS*i +: CFG_BITS]);

    tmr_edge u_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin[i]), .fall(fall[i])
    );

    assign en[i]  = run_q[i] & (~cfg[i].gate | gate_pin[i]);
    assign inc[i] = en[i] & (cfg[i].ext ? fall[i] : tick);

    if (i == 0) begin : g_hi_src
      assign inc_hi_i = run_q[1] & tick;
    end else begin : g_hi_none
      assign inc_hi_i = 1'b0;
    end

    tmr_unit #(.SPLIT(i == 0), .W(8)) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (cfg[i].mode),
      .inc_lo   (inc[i]),
      .inc_hi   (inc_hi_i),
      .wr_lo    (wr_en && (addr == A_LO)),
      .wr_hi    (wr_en && (addr == A_HI)),
      .wr_data  (wr_data),
      .lo       (cnt_lo[i]),
      .hi       (cnt_hi[i]),
      .ovf_main (ovf_main[i]),
      .ovf_hi   (ovf_hi[i])
    );
  end

  // flag sources; timer 0 in split mode takes over flag 1
  assign set_flag[0] = ovf_main[0];
  assign set_flag[1] = t0_split ? ovf_hi[0] : (ovf_main[1] | ovf_hi[1]);

  always_comb begin
    cfg_d  = wr_cfg  ? wr_data : cfg_q;
    run_d  = wr_ctrl ? wr_data[1:0] : run_q;
    flag_d = flag_q;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (ack[i])                   flag_d[i] = 1'b0;
      if (wr_ctrl && wr_data[2+i])  flag_d[i] = 1'b0;
      if (set_flag[i])              flag_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_T0_LO: rd_data = cnt_lo[0];
      ADDR_T0_HI: rd_data = cnt_hi[0];
      ADDR_T1_LO: rd_data = cnt_lo[1];
      ADDR_T1_HI: rd_data = cnt_hi[1];
      ADDR_CFG:   rd_data = cfg_q;
      ADDR_CTRL:  rd_data = {4'b0, flag_q, run_q};
      default:    rd_data = 8'h00;
    endcase
  end

  assign ovf = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wr_data,
  input logic [1:0] ack,
  input logic [1:0] ovf,
  input logic [1:0] run_q,
  input logic [7:0] cfg_q,
  input logic [7:0] t0_lo,
  input logic [7:0] t0_hi,
  input logic [7:0] t1_lo,
  input logic [7:0] t1_hi
);
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_q[0]) && $past(cfg_q[1:0]) != 2'd3 && !$past(wr_en)
      |-> $stable(t0_lo) && $stable(t0_hi)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[0]) && $past(cfg_q[1:0]) == 2'd1 && !$past(wr_en)
      |-> {t0_hi, t0_lo} == 16'h0000); // R6

  AST_RELOAD_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_q[1:0]) == 2'd2 && !$past(wr_en) |-> $stable(t0_hi)); // R7

  AST_T1_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_q[5:4]) == 2'd3 && !$past(wr_en) |-> $stable({t1_hi, t1_lo})); // R9

  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf[0]) |-> $past(ack[0]) ||
      ($past(wr_en) && $past(addr) == 3'd5 && $past(wr_data[2]))); // R10
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .ack(ack), .ovf(ovf), .run_q(run_q), .cfg_q(cfg_q),
  .t0_lo(cnt_lo[0]), .t0_hi(cnt_hi[0]), .t1_lo(cnt_lo[1]), .t1_hi(cnt_hi[1])
);

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] cnt_pin = 2'b00;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ack = 2'b00;
  logic [1:0] ovf;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tmr_pair #(.DIV(DIV)) i_tmr_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ack(ack), .ovf(ovf)
  );

  // {mode, hi, lo, ticks, exp_hi, exp_lo, exp_flag}
  localparam int NV = 8;
  localparam logic [55:0] VEC [NV] = '{
    {8'h01, 8'h00, 8'h00, 8'd5, 8'h00, 8'h05, 8'h00},  // R3 R6 plain count
    {8'h01, 8'h00, 8'hFF, 8'd1, 8'h01, 8'h00, 8'h00},  // R6 carry into high
    {8'h01, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 8'h01},  // R6 wrap sets flag
    {8'h00, 8'h00, 8'h1F, 8'd1, 8'h01, 8'h00, 8'h00},  // R5 prescaler carry
    {8'h00, 8'hFF, 8'hFE, 8'd2, 8'h00, 8'hE0, 8'h01},  // R5 wrap, bits 7:5 kept
    {8'h02, 8'h80, 8'hFE, 8'd3, 8'h80, 8'h81, 8'h01},  // R7 reload from high
    {8'h02, 8'h10, 8'h20, 8'd4, 8'h10, 8'h24, 8'h00},  // R7 no reload
    {8'h03, 8'h00, 8'hFE, 8'd2, 8'h00, 8'h00, 8'h01}   // R8 split low byte
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  // run with control value c for exactly k machine cycles, then stop
  task automatic run_t(input logic [7:0] c, input int k);
    wr(3'd5, c);
    repeat (k * DIV - 1) @(negedge clk);
    wr(3'd5, 8'h00);
  endtask

  task automatic pulse_pin(input int n);
    for (int p = 0; p < n; p++) begin
      cnt_pin[1] = 1'b1;
      repeat (2 * DIV) @(negedge clk);
      cnt_pin[1] = 1'b0;
      repeat (2 * DIV) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset read", d, 8'h00);
    end
    chk("R1 reset ovf", {6'b0, ovf}, 8'h00);

    // table walk on timer 0
    for (int v = 0; v < NV; v++) begin
      wr(3'd5, 8'h0C);
      wr(3'd4, VEC[v][55:48]);
      wr(3'd0, VEC[v][39:32]);
      wr(3'd1, VEC[v][47:40]);
      run_t(8'h01, int'(VEC[v][31:24]));
      rd(3'd1, d); chk($sformatf("R3/mode vec %0d hi", v), d, VEC[v][23:16]);
      rd(3'd0, d); chk($sformatf("R3/mode vec %0d lo", v), d, VEC[v][15:8]);
      chk($sformatf("R5/R6/R7 vec %0d flag", v), {7'b0, ovf[0]}, VEC[v][7:0]);
    end

    // R2 gate: pin low blocks, pin high allows
    wr(3'd5, 8'h0C);
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    gate_pin[0] = 1'b0;
    run_t(8'h01, 3);
    rd(3'd0, d); chk("R2 gated off", d, 8'h00);
    gate_pin[0] = 1'b1;
    run_t(8'h01, 3);
    rd(3'd0, d); chk("R2 gated on", d, 8'h03);
    gate_pin[0] = 1'b0;

    // R4 counter source on timer 1
    wr(3'd4, 8'h60);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd5, 8'h02);
    pulse_pin(3);
    wr(3'd5, 8'h00);
    rd(3'd2, d); chk("R4 edge count", d, 8'h03);

    // R8 split: high byte under run1, timer 1 still counts
    wr(3'd5, 8'h0C);
    wr(3'd4, 8'h13);
    wr(3'd0, 8'h10); wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_t(8'h02, 2);
    rd(3'd1, d); chk("R8 split hi", d, 8'h00);
    rd(3'd0, d); chk("R8 split lo idle", d, 8'h10);
    chk("R8 flag1 from t0 hi", {6'b0, ovf}, 8'h02);
    rd(3'd2, d); chk("R8 t1 still counts", d, 8'h01);
    // R10 writing 0 keeps flag, writing 1 clears
    wr(3'd5, 8'h00);
    chk("R10 write0 keeps", {7'b0, ovf[1]}, 8'h01);
    wr(3'd5, 8'h08);
    chk("R10 write1 clears", {7'b0, ovf[1]}, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_t(8'h02, 2);
    chk("R8 t1 wrap no flag", {7'b0, ovf[1]}, 8'h00);
    rd(3'd2, d); chk("R8 t1 lo", d, 8'h01);
    rd(3'd1, d); chk("R8 split hi count", d, 8'h02);

    // R9 timer 1 in mode 3 holds
    wr(3'd4, 8'h30);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    run_t(8'h02, 3);
    rd(3'd2, d); chk("R9 t1 lo held", d, 8'h34);
    rd(3'd3, d); chk("R9 t1 hi held", d, 8'h12);
    chk("R9 no flag", {7'b0, ovf[1]}, 8'h00);

    // R10 ack in the same cycle as an overflow
    wr(3'd5, 8'h0C);
    wr(3'd4, 8'h02);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
    wr(3'd5, 8'h01);
    for (int i = 0; i < 4 * DIV; i++) begin
      rd(3'd0, d);
      if (d == 8'hFF) break;
      @(negedge clk);
    end
    chk("R10 phase found", d, 8'hFF);
    repeat (DIV - 1) @(negedge clk);
    chk("R10 flag clear before", {7'b0, ovf[0]}, 8'h00);
    ack[0] = 1'b1;
    @(negedge clk);
    ack[0] = 1'b0;
    chk("R10 set beats ack", {7'b0, ovf[0]}, 8'h01);
    wr(3'd5, 8'h00);
    ack[0] = 1'b1;
    @(negedge clk);
    ack[0] = 1'b0;
    chk("R10 ack clears", {7'b0, ovf[0]}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule